// File: doc/BRIEF.md
# Four-Beat Strobed Data Link

This block carries 256-bit transfers across a 64-bit source-synchronous data bus. Each bus clock period moves four 64-bit beats. The sender splits the bus into four 16-bit lanes. Each lane gets its own pair of strobes, one positive-going and one negative-going. Each strobe toggles at twice the bus clock rate, and the two strobes of a pair are interleaved, so that every beat is marked by exactly one strobe rising edge.

The receiver watches each lane on that lane's own strobes and stores the four 16-bit slices into beat slots. It then reassembles the four 64-bit words in beat order and raises an output valid for one bus clock period. The design is modelled in a single clock domain whose clock runs at four times the bus clock. A free-running beat index (0 to 3) marks the quarter periods, and index 0 is the start of each bus clock period. The transmit and receive halves are wired back to back, and the bus lines and strobes are brought out for observation.

Top module: `qp_link`

## Requirements
- R1: `in_ready` is high only in the cycle where `beat_idx` equals 3, once per bus period. A transfer is taken when `in_valid` and `in_ready` are both high, and `in_valid` in any other cycle has no effect on the bus lines.
- R2: For a transfer accepted at the end of a period, `bus_data` carries word b (`in_data[64*b +: 64]`) in the following period, in the cycle where `beat_idx` equals b.
- R3: While a transfer is on the lines, `strb_p` of every lane is high in beats 0 and 2 and `strb_n` is high in beats 1 and 3. P therefore rises at beats 0 and 2 and N rises at beats 1 and 3. P and N of a lane are always complementary.
- R4: In a period with no transfer, the lines idle with `strb_p` all low, `strb_n` all high and `bus_data` zero.
- R5: Every transfer produces exactly two P rising edges and two N rising edges on each of the four lanes.
- R6: Each lane is captured on its own strobes, and `out_data` holds word b at bits `[64*b +: 64]`, equal to the transmitted transfer. Lane g is bus bits `[16*g +: 16]`.
- R7: `out_valid` is high for the four cycles (one bus period) that follow the period in which the transfer was on the lines, `beat_idx` 0 to 3, and `out_data` is stable during them.
- R8: During reset `strb_p` is 0, `strb_n` is all ones, `bus_data` is 0, `out_valid` is 0 and `beat_idx` is 0.
- R9: Transfers in consecutive periods go out and come back with no idle period between them.
- R10: `out_valid` stays low in any period whose preceding period carried no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-period clock (4x bus clock) |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Transfer offered |
| in_data | input | 256 | Four 64-bit words, word 0 in the low bits |
| in_ready | output | 1 | Transfer slot open (last beat of period) |
| bus_data | output | 64 | Data lines |
| strb_p | output | 4 | Positive strobe per 16-bit lane |
| strb_n | output | 4 | Negative strobe per 16-bit lane |
| beat_idx | output | 2 | Current beat within the bus period |
| out_valid | output | 1 | Reassembled transfer available |
| out_data | output | 256 | Reassembled transfer, word 0 in the low bits |

## Verification
Several properties are checked by assertions on every cycle: strobe complementarity, the beat phase of each P and N rising edge, the first beat and the strobe state after an accept, the idle pattern after an empty slot, the realignment of each lane's slot selectors after the fourth beat, and the stability of the output during its valid window. Other behaviours need the bench's scenarios. These are the end-to-end data match across all four lanes, the exact strobe edge count per lane over a run, the gap between isolated transfers, the ignoring of `in_valid` outside the ready slot, and unbroken back-to-back traffic.

// File: rtl/qp_pkg.sv
package qp_pkg;
    localparam int BEATS     = 4;
    localparam int BEAT_W    = $clog2(BEATS);
    localparam int LANES_DEF = 4;
    localparam int LANE_W_DEF = 16;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef struct packed {
        logic p;
        logic n;
    } strobe_pair_t;

    localparam strobe_pair_t STROBE_REST  = '{p: 1'b0, n: 1'b1};
    localparam strobe_pair_t STROBE_FIRST = '{p: 1'b1, n: 1'b0};

    localparam beat_t LAST_BEAT = beat_t'(BEATS - 1);

    function automatic beat_t beat_after(beat_t b);
        return b + beat_t'(1);
    endfunction
endpackage

// File: rtl/qp_beat_ctr.sv
module qp_beat_ctr
    import qp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output beat_t beat
);
    always_ff @(posedge clk) begin
        if (rst) beat <= '0;
        else     beat <= beat_after(beat);
    end
endmodule

// File: rtl/qp_tx.sv
module qp_tx
    import qp_pkg::*;
#(
    parameter int LANES  = LANES_DEF,
    parameter int LANE_W = LANE_W_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  beat_t                       beat,
    input  logic                        in_valid,
    input  logic [LANES*LANE_W*BEATS-1:0] in_data,
    output logic                        in_ready,
    output logic [LANES*LANE_W-1:0]     bus_data,
    output logic [LANES-1:0]            strb_p,
    output logic [LANES-1:0]            strb_n
);
    localparam int BUS_W  = LANES * LANE_W;
    localparam int XFER_W = BUS_W * BEATS;

    logic              act_q;
    logic [XFER_W-1:0] hold_q;
    logic              accept;
    beat_t             nxt;

    assign in_ready = (beat == LAST_BEAT);
    assign accept   = in_valid && in_ready;
    assign nxt      = beat_after(beat);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            hold_q <= '0;
        end else if (beat == LAST_BEAT) begin
            act_q <= accept;
            if (accept) hold_q <= in_data;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        strobe_pair_t            st_q;
        logic [LANE_W-1:0]       d_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q <= STROBE_REST;
                d_q  <= '0;
            end else if (beat == LAST_BEAT) begin
                if (accept) begin
                    st_q <= STROBE_FIRST;
                    d_q  <= in_data[g*LANE_W +: LANE_W];
                end else begin
                    st_q <= STROBE_REST;
                    d_q  <= '0;
                end
            end else if (act_q) begin
                st_q <= '{p: ~st_q.p, n: ~st_q.n};
                d_q  <= hold_q[int'(nxt)*BUS_W + g*LANE_W +: LANE_W];
            end
        end

        assign strb_p[g]                       = st_q.p;
        assign strb_n[g]                       = st_q.n;
        assign bus_data[g*LANE_W +: LANE_W]    = d_q;
    end

    // R2: first beat and first strobe state follow an accept
    a_r2_first_beat: assert property (@(posedge clk) disable iff (rst)
        accept |=> (bus_data == $past(in_data[BUS_W-1:0])) && (strb_p == '1) && (strb_n == '0));

    // R4: an empty slot leaves the lines idle for the next period
    a_r4_idle_lines: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> (strb_p == '0) && (strb_n == '1) && (bus_data == '0));
endmodule

// File: rtl/qp_rx_lane.sv
module qp_rx_lane
    import qp_pkg::*;
#(
    parameter int LANE_W = LANE_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      strb_p,
    input  logic                      strb_n,
    input  logic [LANE_W-1:0]         lane_data,
    output logic [LANE_W*BEATS-1:0]   word_q,
    output logic                      done_q
);
    logic              prev_p, prev_n;
    logic              sel_p, sel_n;
    logic [LANE_W-1:0] s0, s1, s2;
    logic              p_rise, n_rise;

    assign p_rise = strb_p && !prev_p;
    assign n_rise = strb_n && !prev_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_p <= STROBE_REST.p;
            prev_n <= STROBE_REST.n;
            sel_p  <= 1'b0;
            sel_n  <= 1'b0;
            s0     <= '0;
            s1     <= '0;
            s2     <= '0;
            word_q <= '0;
            done_q <= 1'b0;
        end else begin
            prev_p <= strb_p;
            prev_n <= strb_n;
            done_q <= 1'b0;
            if (p_rise) begin
                if (sel_p) s2 <= lane_data;
                else       s0 <= lane_data;
                sel_p <= ~sel_p;
            end
            if (n_rise) begin
                sel_n <= ~sel_n;
                if (sel_n) begin
                    word_q <= {lane_data, s2, s1, s0};
                    done_q <= 1'b1;
                end else begin
                    s1 <= lane_data;
                end
            end
        end
    end

    // R3: the two strobes of a lane never rise together
    a_r3_no_double_rise: assert property (@(posedge clk) disable iff (rst)
        !(p_rise && n_rise));

    // R5: after a lane completes, both slot selectors are back at the first half
    a_r5_realigned: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!sel_p && !sel_n));
endmodule

// File: rtl/qp_rx_merge.sv
module qp_rx_merge
    import qp_pkg::*;
#(
    parameter int LANES  = LANES_DEF,
    parameter int LANE_W = LANE_W_DEF
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [LANES*LANE_W*BEATS-1:0]     lane_words,
    input  logic [LANES-1:0]                  lane_done,
    output logic                              out_valid,
    output logic [LANES*LANE_W*BEATS-1:0]     out_data
);
    localparam int BUS_W = LANES * LANE_W;
    localparam int LW4   = LANE_W * BEATS;

    logic  all_done;
    beat_t hold_cnt;

    assign all_done  = &lane_done;
    assign out_valid = all_done || (hold_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst)                   hold_cnt <= '0;
        else if (all_done)         hold_cnt <= LAST_BEAT;
        else if (hold_cnt != '0)   hold_cnt <= hold_cnt - beat_t'(1);
    end

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign out_data[b*BUS_W + g*LANE_W +: LANE_W] =
                lane_words[g*LW4 + b*LANE_W +: LANE_W];
        end
    end

    // R7: a valid window opens only on a completed transfer
    a_r7_open: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> all_done);

    // R7: data holds still inside a window
    a_r7_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid) && !all_done) |-> $stable(out_data));
endmodule

// File: rtl/qp_link.sv
module qp_link
    import qp_pkg::*;
#(
    parameter int LANES  = LANES_DEF,
    parameter int LANE_W = LANE_W_DEF
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    input  logic [LANES*LANE_W*BEATS-1:0]     in_data,
    output logic                              in_ready,
    output logic [LANES*LANE_W-1:0]           bus_data,
    output logic [LANES-1:0]                  strb_p,
    output logic [LANES-1:0]                  strb_n,
    output logic [BEAT_W-1:0]                 beat_idx,
    output logic                              out_valid,
    output logic [LANES*LANE_W*BEATS-1:0]     out_data
);
    localparam int LW4 = LANE_W * BEATS;

    beat_t                       beat;
    logic [LANES*LW4-1:0]        lane_words;
    logic [LANES-1:0]            lane_done;

    qp_beat_ctr u_ctr (.clk(clk), .rst(rst), .beat(beat));

    qp_tx #(.LANES(LANES), .LANE_W(LANE_W)) u_tx (
        .clk(clk), .rst(rst), .beat(beat),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .bus_data(bus_data), .strb_p(strb_p), .strb_n(strb_n)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_rx
        qp_rx_lane #(.LANE_W(LANE_W)) u_lane (
            .clk(clk), .rst(rst),
            .strb_p(strb_p[g]), .strb_n(strb_n[g]),
            .lane_data(bus_data[g*LANE_W +: LANE_W]),
            .word_q(lane_words[g*LW4 +: LW4]),
            .done_q(lane_done[g])
        );
    end

    qp_rx_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
        .clk(clk), .rst(rst),
        .lane_words(lane_words), .lane_done(lane_done),
        .out_valid(out_valid), .out_data(out_data)
    );

    assign beat_idx = beat;

    // R3: each lane's strobes are complementary at all times
    a_r3_complement: assert property (@(posedge clk) disable iff (rst)
        strb_p == ~strb_n);

    // R3: P rises only at even beats
    a_r3_p_even: assert property (@(posedge clk) disable iff (rst)
        $rose(strb_p[0]) |-> !beat[0]);

    // R3: N rises only at odd beats
    a_r3_n_odd: assert property (@(posedge clk) disable iff (rst)
        $rose(strb_n[0]) |-> beat[0]);

    // R1: the ready slot is the last beat of a period
    a_r1_ready_slot: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> (beat == '0));
endmodule

// File: tb/qp_link_test.sv
module qp_link_test;
    localparam int BW = 64;
    localparam int XW = 256;
    localparam int NPER = 400;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [XW-1:0] in_data = '0;
    logic          in_ready;
    logic [BW-1:0] bus_data;
    logic [3:0]    strb_p, strb_n;
    logic [1:0]    beat_idx;
    logic          out_valid;
    logic [XW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    qp_link uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .bus_data(bus_data), .strb_p(strb_p), .strb_n(strb_n),
        .beat_idx(beat_idx), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [XW-1:0] rand_xfer();
        logic [XW-1:0] v;
        for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [XW-1:0] dir_xfer(int k);
        logic [XW-1:0] v;
        case (k)
            0: v = '0;
            1: v = '1;
            2: v = {64{4'h5}};
            3: v = {64{4'hA}};
            default: begin
                for (int b = 0; b < 4; b++)
                    for (int g = 0; g < 4; g++)
                        v[64*b + 16*g +: 16] = 16'(16'h1000 * (b + 1) + 16'h0100 * (g + 1) + k);
            end
        endcase
        return v;
    endfunction

    task automatic check(bit ok, string req, logic [XW-1:0] act, logic [XW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        logic          line_act, eo_act, drv_v;
        logic [XW-1:0] line_data, eo_data, drv_d;
        logic [1:0]    ex_beat;
        logic [3:0]    prev_p, prev_n;
        int            rise_p [4];
        int            rise_n [4];
        int            sent;
        int            per;

        void'($urandom(32'd20240611));
        line_act = 0; eo_act = 0; line_data = '0; eo_data = '0;
        prev_p = '0; prev_n = '1; sent = 0; per = 0; ex_beat = 2'd1;
        for (int g = 0; g < 4; g++) begin rise_p[g] = 0; rise_n[g] = 0; end

        repeat (3) @(negedge clk);
        // R8: reset state
        check(strb_p == '0 && strb_n == '1, "R8 strobes", XW'({strb_p, strb_n}), XW'(8'h0F));
        check(bus_data == '0 && beat_idx == '0, "R8 lines", XW'({bus_data, beat_idx}), '0);
        check(out_valid == 1'b0, "R8 out_valid", XW'(out_valid), '0);
        rst = 1'b0;

        while (per < NPER + 3) begin
            @(negedge clk);
            // R1: ready slot
            check(beat_idx == ex_beat, "R1 beat index", XW'(beat_idx), XW'(ex_beat));
            check(in_ready == (ex_beat == 2'd3), "R1 in_ready", XW'(in_ready), XW'(ex_beat == 2'd3));
            // R2/R3/R4: lines
            if (line_act) begin
                check(bus_data == line_data[64*ex_beat +: 64], "R2 beat data",
                      XW'(bus_data), XW'(line_data[64*ex_beat +: 64]));
                check(strb_p == {4{~ex_beat[0]}} && strb_n == {4{ex_beat[0]}}, "R3 strobe phase",
                      XW'({strb_p, strb_n}), XW'({{4{~ex_beat[0]}}, {4{ex_beat[0]}}}));
            end else begin
                check(bus_data == '0 && strb_p == '0 && strb_n == '1, "R4 idle lines",
                      XW'({bus_data, strb_p, strb_n}), XW'(8'h0F));
            end
            // R7/R10: valid window; R6: data
            check(out_valid == eo_act, "R7 R10 out_valid", XW'(out_valid), XW'(eo_act));
            if (out_valid && eo_act)
                check(out_data == eo_data, "R6 R9 out_data", out_data, eo_data);
            // R5: rise counting
            for (int g = 0; g < 4; g++) begin
                if (strb_p[g] && !prev_p[g]) rise_p[g]++;
                if (strb_n[g] && !prev_n[g]) rise_n[g]++;
            end
            prev_p = strb_p; prev_n = strb_n;

            // stimulus
            drv_v = 1'b0; drv_d = rand_xfer();
            if (ex_beat == 2'd3) begin
                if (per < 6)                       begin drv_v = 1'b1; drv_d = dir_xfer(per); end
                else if (per < 10)                 drv_v = 1'b0;
                else if (per == 10)                begin drv_v = 1'b1; drv_d = dir_xfer(7); end
                else if (per < 14)                 drv_v = 1'b0;
                else if (per < 30)                 drv_v = 1'b1;
                else if (per < NPER)               drv_v = ($urandom_range(0, 9) < 7);
            end else begin
                drv_v = ($urandom_range(0, 3) == 0); // R1: outside the slot, ignored
            end
            in_valid = drv_v;
            in_data  = drv_d;

            if (ex_beat == 2'd3) begin
                eo_act = line_act; eo_data = line_data;
                line_act = drv_v; line_data = drv_d;
                if (drv_v) sent++;
                per++;
            end
            ex_beat = ex_beat + 2'd1;
        end
        in_valid = 1'b0;

        // R5: exactly two P and two N rises per lane per transfer
        for (int g = 0; g < 4; g++) begin
            check(rise_p[g] == 2 * sent, "R5 P rises", XW'(rise_p[g]), XW'(2 * sent));
            check(rise_n[g] == 2 * sent, "R5 N rises", XW'(rise_n[g]), XW'(2 * sent));
        end
        finished = 1'b1;
        summary();
    end
endmodule